// File: doc/BRIEF.md
# Compare-Branch Fusion Stage

This stage sits between an instruction pre-decoder and the micro-op issue stage. It takes one simplified instruction record per cycle and emits one micro-op per cycle. A record holds a kind, two operands, a condition code and a branch target. When a flag-producing compare or test is directly followed by a conditional branch, and that pairing is allowed, the stage merges the two into a single fused micro-op. Every other instruction passes through unchanged.

A compare or test is never sent out straight away. It is parked in a one-entry holding slot so that the stage can see the next record. If the next cycle brings a fusible branch, the pair leaves as one micro-op. If the next cycle brings nothing, or brings anything else, the compare leaves alone. Two static inputs set the policy. The first is a legacy switch, which confines fusion to 32-bit mode and to equality and unsigned conditions. The second is a mode bit that selects 32-bit or 64-bit operation. The output uses a valid/ready handshake, and a flush input discards everything in flight.

Top module: `mf_fusion_unit`

## Requirements
- R1: An instruction that is not a compare (kind 1) or a test (kind 2) is emitted unchanged with the fused flag low, provided no compare is being held. The other kinds are 0, 3 (conditional branch) and 4 to 7.
- R2: A held compare or test followed by an accepted fusible conditional branch produces exactly one micro-op. It has the fused flag set, the compare's kind and operands, and the branch's condition and target.
- R3: With the legacy switch low, fusion is allowed in both 32-bit mode (mode bit 0) and 64-bit mode (mode bit 1).
- R4: With the legacy switch high and the mode bit at 1 (64-bit), no fusion takes place. The compare and the branch leave as two separate micro-ops.
- R5: Which conditions may fuse is set per condition code. The unsigned and equality codes 2 to 7 may fuse in both configurations. The signed codes 12 to 15 may fuse only with the legacy switch low. Codes 0, 1 and 8 to 11 never fuse.
- R6: An accepted compare or test is held back for one cycle. If no valid instruction is offered in the next cycle the output can advance, the compare is emitted alone with the fused flag low.
- R7: While the output holds a valid micro-op that is not taken, the micro-op stays stable and in_ready is low. No instruction is lost or duplicated.
- R8: A flush drops the held compare and the output micro-op. In the following cycle out_valid is low.
- R9: When a compare is held and the offered instruction cannot fuse with it, the compare is emitted alone first. The offered instruction is not accepted in that cycle.
- R10: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard held and pending work |
| mode64 | input | 1 | 1 = 64-bit operation, 0 = 32-bit |
| legacy_cfg | input | 1 | 1 = restricted fusion policy |
| in_valid | input | 1 | Input record valid |
| in_ready | output | 1 | Input record accepted this cycle |
| in_kind | input | 3 | Instruction kind |
| in_src_a | input | DATA_W | First operand |
| in_src_b | input | DATA_W | Second operand |
| in_cond | input | COND_W | Condition code |
| in_target | input | TGT_W | Branch target |
| out_valid | output | 1 | Micro-op valid |
| out_ready | input | 1 | Downstream takes micro-op |
| out_fused | output | 1 | Micro-op is a fused pair |
| out_kind | output | 3 | Micro-op kind |
| out_src_a | output | DATA_W | First operand |
| out_src_b | output | DATA_W | Second operand |
| out_cond | output | COND_W | Condition code |
| out_target | output | TGT_W | Branch target |

## Verification
The assertions assume that the mode bit and the legacy switch change only between instructions, never while a compare is being held. They also assume that a record offered but not accepted is offered again unchanged. The random stimulus changes the policy inputs only in quiet phases in which nothing is held. It keeps each refused record on the inputs until the stage accepts it or a flush occurs. A flush lets the bench draw a fresh record, and that is permitted because a flush discards the pending one.

// File: rtl/mf_pkg.sv
package mf_pkg;
  typedef enum logic [2:0] {
    K_ALU   = 3'd0,
    K_CMP   = 3'd1,
    K_TEST  = 3'd2,
    K_JCC   = 3'd3,
    K_JMP   = 3'd4,
    K_LOAD  = 3'd5,
    K_STORE = 3'd6,
    K_NOP   = 3'd7
  } kind_e;

  function automatic logic is_flag_setter(input logic [2:0] k);
    return (k == K_CMP) || (k == K_TEST);
  endfunction

  function automatic logic is_cond_branch(input logic [2:0] k);
    return k == K_JCC;
  endfunction

  // Legacy policy: fusion only outside 64-bit mode.
  function automatic logic mode_allows(input logic legacy, input logic m64);
    return !(legacy && m64);
  endfunction
endpackage

// File: rtl/mf_cond_table.sv
module mf_cond_table #(
  parameter int          COND_W      = 4,
  parameter logic [15:0] BASE_MASK   = 16'h00FC,
  parameter logic [15:0] SIGNED_MASK = 16'hF000
) (
  input  logic              legacy,
  input  logic [COND_W-1:0] cond,
  output logic              eligible
);
  localparam int NCOND = 1 << COND_W;

  logic [NCOND-1:0] base_row;
  logic [NCOND-1:0] wide_row;

  for (genvar c = 0; c < NCOND; c++) begin : g_row
    if (c < 16) begin : g_in
      assign base_row[c] = BASE_MASK[c];
      assign wide_row[c] = BASE_MASK[c] | SIGNED_MASK[c];
    end else begin : g_out
      assign base_row[c] = 1'b0;
      assign wide_row[c] = 1'b0;
    end
  end

  assign eligible = legacy ? base_row[cond] : wide_row[cond];
endmodule

// File: rtl/mf_hold_slot.sv
module mf_hold_slot #(
  parameter int DATA_W = 32,
  parameter int COND_W = 4,
  parameter int TGT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drop,
  input  logic              load,
  input  logic              release_now,
  input  logic [2:0]        d_kind,
  input  logic [DATA_W-1:0] d_a,
  input  logic [DATA_W-1:0] d_b,
  input  logic [COND_W-1:0] d_cond,
  input  logic [TGT_W-1:0]  d_target,
  output logic              q_valid,
  output logic [2:0]        q_kind,
  output logic [DATA_W-1:0] q_a,
  output logic [DATA_W-1:0] q_b,
  output logic [COND_W-1:0] q_cond,
  output logic [TGT_W-1:0]  q_target
);
  always_ff @(posedge clk) begin
    if (!rst_n || drop) begin
      q_valid <= 1'b0;
    end else if (load) begin
      q_valid <= 1'b1;
    end else if (release_now) begin
      q_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      q_kind   <= d_kind;
      q_a      <= d_a;
      q_b      <= d_b;
      q_cond   <= d_cond;
      q_target <= d_target;
    end
  end
endmodule

// File: rtl/mf_out_stage.sv
module mf_out_stage #(
  parameter int DATA_W = 32,
  parameter int COND_W = 4,
  parameter int TGT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drop,
  input  logic              advance,
  input  logic              fill,
  input  logic              d_fused,
  input  logic [2:0]        d_kind,
  input  logic [DATA_W-1:0] d_a,
  input  logic [DATA_W-1:0] d_b,
  input  logic [COND_W-1:0] d_cond,
  input  logic [TGT_W-1:0]  d_target,
  output logic              q_valid,
  output logic              q_fused,
  output logic [2:0]        q_kind,
  output logic [DATA_W-1:0] q_a,
  output logic [DATA_W-1:0] q_b,
  output logic [COND_W-1:0] q_cond,
  output logic [TGT_W-1:0]  q_target
);
  always_ff @(posedge clk) begin
    if (!rst_n || drop) begin
      q_valid <= 1'b0;
    end else if (advance) begin
      q_valid <= fill;
    end
  end

  always_ff @(posedge clk) begin
    if (advance && fill) begin
      q_fused  <= d_fused;
      q_kind   <= d_kind;
      q_a      <= d_a;
      q_b      <= d_b;
      q_cond   <= d_cond;
      q_target <= d_target;
    end
  end
endmodule

// File: rtl/mf_fusion_unit.sv
module mf_fusion_unit #(
  parameter int          DATA_W      = 32,
  parameter int          COND_W      = 4,
  parameter int          TGT_W       = 32,
  parameter logic [15:0] BASE_MASK   = 16'h00FC,
  parameter logic [15:0] SIGNED_MASK = 16'hF000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              mode64,
  input  logic              legacy_cfg,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_kind,
  input  logic [DATA_W-1:0] in_src_a,
  input  logic [DATA_W-1:0] in_src_b,
  input  logic [COND_W-1:0] in_cond,
  input  logic [TGT_W-1:0]  in_target,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_fused,
  output logic [2:0]        out_kind,
  output logic [DATA_W-1:0] out_src_a,
  output logic [DATA_W-1:0] out_src_b,
  output logic [COND_W-1:0] out_cond,
  output logic [TGT_W-1:0]  out_target
);
  import mf_pkg::*;

  // Holding slot contents
  logic              hold_v;
  logic [2:0]        hold_kind;
  logic [DATA_W-1:0] hold_a;
  logic [DATA_W-1:0] hold_b;
  logic [COND_W-1:0] hold_cond;
  logic [TGT_W-1:0]  hold_target;

  // Named events, also watched by the checker
  logic advance;
  logic cond_ok;
  logic pair_ok;
  logic fuse_fire;
  logic solo_fire;
  logic pass_fire;
  logic capture;

  // Next output micro-op
  logic              nx_fused;
  logic [2:0]        nx_kind;
  logic [DATA_W-1:0] nx_a;
  logic [DATA_W-1:0] nx_b;
  logic [COND_W-1:0] nx_cond;
  logic [TGT_W-1:0]  nx_target;

  mf_cond_table #(
    .COND_W(COND_W), .BASE_MASK(BASE_MASK), .SIGNED_MASK(SIGNED_MASK)
  ) u_table (
    .legacy   (legacy_cfg),
    .cond     (in_cond),
    .eligible (cond_ok)
  );

  assign advance   = !out_valid || out_ready;
  assign pair_ok   = hold_v && in_valid && is_cond_branch(in_kind) && cond_ok
                     && mode_allows(legacy_cfg, mode64);
  assign fuse_fire = advance && !flush && pair_ok;
  assign solo_fire = advance && !flush && hold_v && !pair_ok;
  assign pass_fire = advance && !flush && !hold_v && in_valid && !is_flag_setter(in_kind);
  assign capture   = advance && !flush && !hold_v && in_valid && is_flag_setter(in_kind);
  assign in_ready  = advance && !flush && (!hold_v || pair_ok);

  always_comb begin
    nx_fused  = 1'b0;
    nx_kind   = in_kind;
    nx_a      = in_src_a;
    nx_b      = in_src_b;
    nx_cond   = in_cond;
    nx_target = in_target;
    if (hold_v) begin
      nx_kind = hold_kind;
      nx_a    = hold_a;
      nx_b    = hold_b;
      if (pair_ok) begin
        nx_fused = 1'b1;
      end else begin
        nx_cond   = hold_cond;
        nx_target = hold_target;
      end
    end
  end

  mf_hold_slot #(.DATA_W(DATA_W), .COND_W(COND_W), .TGT_W(TGT_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .drop        (flush),
    .load        (capture),
    .release_now (fuse_fire || solo_fire),
    .d_kind      (in_kind),
    .d_a         (in_src_a),
    .d_b         (in_src_b),
    .d_cond      (in_cond),
    .d_target    (in_target),
    .q_valid     (hold_v),
    .q_kind      (hold_kind),
    .q_a         (hold_a),
    .q_b         (hold_b),
    .q_cond      (hold_cond),
    .q_target    (hold_target)
  );

  mf_out_stage #(.DATA_W(DATA_W), .COND_W(COND_W), .TGT_W(TGT_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .drop     (flush),
    .advance  (advance),
    .fill     (fuse_fire || solo_fire || pass_fire),
    .d_fused  (nx_fused),
    .d_kind   (nx_kind),
    .d_a      (nx_a),
    .d_b      (nx_b),
    .d_cond   (nx_cond),
    .d_target (nx_target),
    .q_valid  (out_valid),
    .q_fused  (out_fused),
    .q_kind   (out_kind),
    .q_a      (out_src_a),
    .q_b      (out_src_b),
    .q_cond   (out_cond),
    .q_target (out_target)
  );
endmodule

// File: rtl/mf_fusion_checker.sv
module mf_fusion_checker #(
  parameter int DATA_W = 32,
  parameter int TGT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              mode64,
  input logic              legacy_cfg,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_fused,
  input logic [2:0]        out_kind,
  input logic [DATA_W-1:0] out_src_a,
  input logic [TGT_W-1:0]  out_target,
  input logic              fuse_fire,
  input logic              solo_fire,
  input logic              pass_fire,
  input logic              capture
);
  p_fuse_emits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_fire |=> (out_valid && out_fused));

  p_fused_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fused) |-> (out_kind == 3'd1 || out_kind == 3'd2));

  p_legacy64_nofuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_cfg && mode64) |-> !fuse_fire);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=>
      (out_valid && $stable(out_src_a) && $stable(out_target) && $stable(out_fused)));

  p_ready_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_flush_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);

  p_one_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fuse_fire, solo_fire, pass_fire, capture}));
endmodule

bind mf_fusion_unit mf_fusion_checker #(.DATA_W(DATA_W), .TGT_W(TGT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .mode64     (mode64),
  .legacy_cfg (legacy_cfg),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_fused  (out_fused),
  .out_kind   (out_kind),
  .out_src_a  (out_src_a),
  .out_target (out_target),
  .fuse_fire  (fuse_fire),
  .solo_fire  (solo_fire),
  .pass_fire  (pass_fire),
  .capture    (capture)
);

// File: tb/sim_mf_fusion_unit.sv
module sim_mf_fusion_unit;
  localparam int CLK_P = 10;
  localparam int DW = 32;
  localparam int CW = 4;
  localparam int TW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0, mode64 = 1'b0, legacy_cfg = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [2:0] in_kind = '0;
  logic [DW-1:0] in_src_a = '0, in_src_b = '0;
  logic [CW-1:0] in_cond = '0;
  logic [TW-1:0] in_target = '0;
  logic out_valid, out_ready = 1'b1, out_fused;
  logic [2:0] out_kind;
  logic [DW-1:0] out_src_a, out_src_b;
  logic [CW-1:0] out_cond;
  logic [TW-1:0] out_target;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  bit last_acc;

  // Reference state, written from the requirements
  bit m_ov, m_of, m_hv;
  logic [2:0] m_ok, h_k;
  logic [DW-1:0] m_oa, m_ob, h_a, h_b;
  logic [CW-1:0] m_oc, h_c;
  logic [TW-1:0] m_ot, h_t;
  string m_tag = "R10";

  mf_fusion_unit #(.DATA_W(DW), .COND_W(CW), .TGT_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .mode64(mode64), .legacy_cfg(legacy_cfg),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_src_a(in_src_a),
    .in_src_b(in_src_b), .in_cond(in_cond), .in_target(in_target),
    .out_valid(out_valid), .out_ready(out_ready), .out_fused(out_fused), .out_kind(out_kind),
    .out_src_a(out_src_a), .out_src_b(out_src_b), .out_cond(out_cond), .out_target(out_target)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic bit cond_may_fuse(input logic [3:0] c, input bit legacy);
    bit unsigned_set = (c >= 4'd2) && (c <= 4'd7);
    bit signed_set   = (c >= 4'd12);
    return unsigned_set || (!legacy && signed_set);
  endfunction

  function automatic bit can_pair(input logic [2:0] k, input logic [3:0] c,
                                  input bit m64, input bit legacy);
    return (k == 3'd3) && cond_may_fuse(c, legacy) && !(legacy && m64);
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // One cycle: drive at negedge, predict, compare at the next negedge
  task automatic step(input bit v, input logic [2:0] k, input logic [DW-1:0] a,
                      input logic [DW-1:0] b, input logic [CW-1:0] c,
                      input logic [TW-1:0] t, input bit rdy, input bit fl);
    bit adv, pr, exp_rdy;
    in_valid = v; in_kind = k; in_src_a = a; in_src_b = b; in_cond = c; in_target = t;
    out_ready = rdy; flush = fl;
    #1;
    adv = !m_ov || rdy;
    pr = m_hv && v && can_pair(k, c, mode64, legacy_cfg);
    exp_rdy = adv && !fl && (!m_hv || pr);
    last_acc = v && exp_rdy;
    if (v) check(m_hv ? "R9" : "R7", "in_ready", in_ready, exp_rdy);
    if (fl) begin
      m_ov = 0; m_hv = 0; m_tag = "R8";
    end else if (!adv) begin
      m_tag = "R7";
    end else if (m_hv) begin
      m_ov = 1; m_ok = h_k; m_oa = h_a; m_ob = h_b; m_hv = 0;
      if (pr) begin
        m_of = 1; m_oc = c; m_ot = t; m_tag = mode64 ? "R3" : "R2";
      end else begin
        m_of = 0; m_oc = h_c; m_ot = h_t;
        if (!v) m_tag = "R6";
        else if (k == 3'd3 && legacy_cfg && mode64) m_tag = "R4";
        else if (k == 3'd3) m_tag = "R5";
        else m_tag = "R9";
      end
    end else if (v && (k == 3'd1 || k == 3'd2)) begin
      m_hv = 1; h_k = k; h_a = a; h_b = b; h_c = c; h_t = t; m_ov = 0; m_tag = "R6";
    end else if (v) begin
      m_ov = 1; m_of = 0; m_ok = k; m_oa = a; m_ob = b; m_oc = c; m_ot = t; m_tag = "R1";
    end else begin
      m_ov = 0; m_tag = "R1";
    end
    @(negedge clk);
    check(m_tag, "out_valid", out_valid, m_ov);
    if (m_ov) begin
      check(m_tag, "out_fused", out_fused, m_of);
      check(m_tag, "out_kind", out_kind, m_ok);
      check(m_tag, "out_src_a", out_src_a, m_oa);
      check(m_tag, "out_src_b", out_src_b, m_ob);
      check(m_tag, "out_cond", out_cond, m_oc);
      check(m_tag, "out_target", out_target, m_ot);
    end
  endtask

  task automatic send(input logic [2:0] k, input logic [CW-1:0] c, input logic [DW-1:0] a);
    do step(1, k, a, a ^ 32'h5A5A, c, a + 32'h100, 1, 0); while (!last_acc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 3'd0, '0, '0, '0, '0, 1, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R10", "out_valid after reset", out_valid, 0);
    check("R10", "in_ready after reset", in_ready, 1);
    @(negedge clk);

    // R3: enhanced policy, 64-bit, signed condition fuses
    legacy_cfg = 0; mode64 = 1;
    send(3'd1, 4'hC, 32'h11); send(3'd3, 4'hC, 32'h22); idle(2);
    // R4: legacy policy in 64-bit mode, equality does not fuse
    legacy_cfg = 1; mode64 = 1;
    send(3'd1, 4'h4, 32'h33); send(3'd3, 4'h4, 32'h44); idle(2);
    // R2/R5: legacy in 32-bit: equality fuses, signed does not
    mode64 = 0;
    send(3'd2, 4'h4, 32'h55); send(3'd3, 4'h4, 32'h66); idle(1);
    send(3'd1, 4'hF, 32'h77); send(3'd3, 4'hF, 32'h88); idle(2);
    // R5: overflow condition never fuses
    legacy_cfg = 0;
    send(3'd1, 4'h0, 32'h99); send(3'd3, 4'h0, 32'hAA); idle(2);
    // R6: compare followed by a gap leaves alone
    send(3'd1, 4'h5, 32'hBB); idle(3);
    // R9: compare then an ordinary instruction
    send(3'd1, 4'h5, 32'hCC); send(3'd0, 4'h5, 32'hDD); idle(2);
    // R8: flush drops a held compare
    send(3'd1, 4'h4, 32'hEE);
    step(0, 3'd0, '0, '0, '0, '0, 1, 1);
    idle(2);
    // R7: stalled output with a fusible pair behind it
    send(3'd0, 4'h0, 32'h1234);
    step(1, 3'd1, 32'h2, 32'h3, 4'h4, 32'h4, 0, 0);
    step(1, 3'd1, 32'h2, 32'h3, 4'h4, 32'h4, 0, 0);
    step(1, 3'd1, 32'h2, 32'h3, 4'h4, 32'h4, 1, 0);
    send(3'd3, 4'h2, 32'h9); idle(2);

    // Random phase with a fixed seed
    begin
      int seed_dummy;
      bit pv;
      logic [2:0] pk;
      logic [DW-1:0] pa, pb;
      logic [CW-1:0] pc;
      logic [TW-1:0] pt;
      seed_dummy = $urandom(1234);
      pv = 0; pk = 0; pa = 0; pb = 0; pc = 0; pt = 0;
      for (int cyc = 0; cyc < 6000; cyc++) begin
        bit rdy, fl;
        int r;
        if (cyc % 500 == 499) begin
          idle(3);
          mode64 = $urandom_range(0, 1);
          legacy_cfg = $urandom_range(0, 1);
          pv = 0;
        end
        if (!pv || last_acc) begin
          pv = ($urandom_range(0, 9) < 8);
          r = $urandom_range(0, 9);
          pk = (r < 3) ? 3'($urandom_range(1, 2)) : (r < 6) ? 3'd3 : 3'($urandom_range(0, 7));
          pa = $urandom; pb = $urandom; pc = 4'($urandom); pt = $urandom;
        end
        rdy = ($urandom_range(0, 3) != 0);
        fl = ($urandom_range(0, 49) == 0);
        step(pv, pk, pa, pb, pc, pt, rdy, fl);
        if (fl) pv = 0;
      end
    end
    idle(3);
    finish_run();
  end
endmodule